// File: doc/BRIEF.md
# Byte-serial carry-less multiply-accumulate unit

This unit builds wide binary-polynomial products one byte step at a time. Every step takes an incoming byte `rr_i` and a stored coefficient byte `rc_q`, forms their 8x8 carry-less product, and folds in two more terms: an accumulator byte `rd_i` and a hidden 8-bit carry register `xc`. All four terms are summed with XOR. The low byte of the sum goes out on `rd_o`, and the high byte is kept in `xc` for the next step. Software streams the bytes of one operand past a fixed byte of the other and gets a running partial-product row. It reads the carry out, which also empties it, by issuing a step with both data bytes at zero.

The coefficient is written through its own load port and is held until the next write. The same partial-product tree also serves an integer multiply-accumulate selected by `int_mode_i`. In that mode the terms are added arithmetically and the result arrives one cycle later than in the carry-less mode. A synchronous clear empties the carry register and cancels any integer step that has not yet completed.

Top module: `clmac_unit`

## Requirements
- R1: A carry-less step accepted at a clock edge (`op_valid_i`=1, `busy_o`=0, `clr_i`=0, `int_mode_i`=0) forms T = clmul(rr_i, rc) ^ {8'h00, xc} ^ {8'h00, rd_i}. After that edge, `rd_o` = T[7:0] and `done_o` = 1 for one cycle.
- R2: The same edge loads T[15:8] into `xc`, and the next step uses that value.
- R3: `rc_we_i`=1 loads `rc_i` into the coefficient register. The value stays until the next load. A step accepted at the same edge as a load uses the previous coefficient.
- R4: A step with `rr_i`=0 and `rd_i`=0 returns the current `xc` on `rd_o` and leaves `xc` at zero. Two such carry-less steps in a row return zero on the second.
- R5: An integer step (`int_mode_i`=1) computes T = rr_i*rc + xc + rd_i as unsigned integers. `busy_o` is 1 in the cycle after acceptance. At the following edge `rd_o` = T[7:0], `xc` = T[15:8] and `done_o` = 1.
- R6: A strobe raised while `busy_o`=1 is ignored. It produces no result and leaves `xc` unchanged.
- R7: `clr_i`=1 zeroes `xc` at the next edge. A strobe in the same cycle is ignored, and a pending integer step is cancelled without a `done_o` pulse.
- R8: After reset, `rd_o`=0, `done_o`=0, `busy_o`=0, and both `xc` and the coefficient are 0.
- R9: Chaining steps row by row (coefficient = byte p of A, for each byte n of B update byte p+n, then a save step into byte p+8) yields the 128-bit carry-less product of two 64-bit polynomials.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the carry register |
| rc_we_i | input | 1 | Coefficient load strobe |
| rc_i | input | W | Coefficient byte |
| op_valid_i | input | 1 | Step strobe |
| int_mode_i | input | 1 | 0: carry-less, 1: integer |
| rr_i | input | W | Multiplier byte |
| rd_i | input | W | Accumulator byte in |
| rd_o | output | W | Accumulator byte out |
| done_o | output | 1 | Result on `rd_o` is new this cycle |
| busy_o | output | 1 | Integer step in its second cycle |

## Verification
The carry register can only be observed indirectly, through a save step. The hardest behaviours to reach from the ports are therefore those that must leave it untouched or cleared: a strobe that arrives during the integer second cycle, and a clear that lands on a pending integer step. The stimulus first charges the carry with a product whose high byte is nonzero. It then holds the strobe high through the busy cycle with different data, or raises the clear in that cycle, and follows with back-to-back save steps that expose the register. Coefficient sweeps that include 0x00 and 0xFF, together with chained 64-bit polynomial products, cover the carry feedback path.

// File: rtl/clmac_pkg.sv
package clmac_pkg;
  typedef enum logic {
    FIELD_BIN = 1'b0,
    FIELD_INT = 1'b1
  } field_e;
endpackage

// File: rtl/clmac_ppgen.sv
module clmac_ppgen #(
  parameter int W = 8
) (
  input  logic [W-1:0]                mcand_i,
  input  logic [W-1:0]                mplier_i,
  output logic [W-1:0][2*W-1:0]       row_o
);
  localparam int PW = 2 * W;

  for (genvar i = 0; i < W; i++) begin : g_row
    assign row_o[i] = mplier_i[i] ? (PW'(mcand_i) << i) : '0;
  end
endmodule

// File: rtl/clmac_tree.sv
module clmac_tree #(
  parameter int W = 8
) (
  input  logic [W-1:0][2*W-1:0] row_i,
  input  logic [W-1:0]          acc_i,
  input  logic [W-1:0]          xc_i,
  output logic [2*W-1:0]        xr_o,
  output logic [2*W-1:0]        half_a_o,
  output logic [2*W-1:0]        half_b_o
);
  localparam int PW = 2 * W;

  // Carry-less sum and two integer half-sums share the same row terms;
  // accumulator and carry enter as extra rows.
  always_comb begin
    xr_o     = PW'(acc_i) ^ PW'(xc_i);
    half_a_o = PW'(acc_i);
    half_b_o = PW'(xc_i);
    for (int i = 0; i < W; i++) begin
      xr_o = xr_o ^ row_i[i];
      if (i % 2 == 0) half_a_o = half_a_o + row_i[i];
      else            half_b_o = half_b_o + row_i[i];
    end
  end
endmodule

// File: rtl/clmac_unit.sv
module clmac_unit
  import clmac_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         rc_we_i,
  input  logic [W-1:0] rc_i,
  input  logic         op_valid_i,
  input  logic         int_mode_i,
  input  logic [W-1:0] rr_i,
  input  logic [W-1:0] rd_i,
  output logic [W-1:0] rd_o,
  output logic         done_o,
  output logic         busy_o
);
  localparam int PW = 2 * W;

  field_e                mode;
  logic                  accept, acc_bin, acc_int;
  logic [W-1:0]          rc_q, xc_q, rd_q;
  logic                  busy_q, done_q;
  logic [W-1:0][PW-1:0]  rows;
  logic [PW-1:0]         xr, half_a, half_b;
  logic [PW-1:0]         sa_q, sb_q, int_sum;

  assign mode    = field_e'(int_mode_i);
  assign accept  = op_valid_i && !busy_q && !clr_i;
  assign acc_bin = accept && (mode == FIELD_BIN);
  assign acc_int = accept && (mode == FIELD_INT);

  clmac_ppgen #(.W(W)) i_ppgen (
    .mcand_i  (rc_q),
    .mplier_i (rr_i),
    .row_o    (rows)
  );

  clmac_tree #(.W(W)) i_tree (
    .row_i    (rows),
    .acc_i    (rd_i),
    .xc_i     (xc_q),
    .xr_o     (xr),
    .half_a_o (half_a),
    .half_b_o (half_b)
  );

  // Second integer cycle: carry-propagate add of the two half-sums
  assign int_sum = sa_q + sb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rc_q <= '0;
    end else if (rc_we_i) begin
      rc_q <= rc_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sa_q <= '0;
      sb_q <= '0;
    end else if (acc_int) begin
      sa_q <= half_a;
      sb_q <= half_b;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      xc_q   <= '0;
      rd_q   <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      busy_q <= acc_int;
      done_q <= acc_bin || (busy_q && !clr_i);
      if (clr_i) begin
        xc_q <= '0;
      end else if (acc_bin) begin
        xc_q <= xr[PW-1:W];
        rd_q <= xr[W-1:0];
      end else if (busy_q) begin
        xc_q <= int_sum[PW-1:W];
        rd_q <= int_sum[W-1:0];
      end
    end
  end

  assign rd_o   = rd_q;
  assign done_o = done_q;
  assign busy_o = busy_q;
endmodule

// File: rtl/clmac_unit_chk.sv
module clmac_unit_chk #(
  parameter int W = 8
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         clr_i,
  input logic         rc_we_i,
  input logic         op_valid_i,
  input logic         int_mode_i,
  input logic [W-1:0] rr_i,
  input logic [W-1:0] rd_i,
  input logic [W-1:0] rd_o,
  input logic         done_o,
  input logic         busy_o,
  input logic [W-1:0] rc_q
);
  logic go, save_bin;
  assign go       = op_valid_i && !busy_o && !clr_i;
  assign save_bin = go && !int_mode_i && (rr_i == '0) && (rd_i == '0);

  // R1
  cl_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && !int_mode_i) |=> (done_o && !busy_o));

  // R5
  int_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (go && int_mode_i) |=> (busy_o && !done_o));

  // R5
  int_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !clr_i) |=> (done_o && !busy_o));

  // R6
  busy_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && busy_o));

  // R7
  clr_cancel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (!done_o && !busy_o));

  // R3
  rc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rc_we_i |=> $stable(rc_q));

  // R4
  save_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (save_bin && $past(save_bin)) |=> (rd_o == '0));

  // R8
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (!done_o && !busy_o && rd_o == '0 && rc_q == '0);
    end
  end
endmodule

bind clmac_unit clmac_unit_chk #(.W(W)) i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .clr_i      (clr_i),
  .rc_we_i    (rc_we_i),
  .op_valid_i (op_valid_i),
  .int_mode_i (int_mode_i),
  .rr_i       (rr_i),
  .rd_i       (rd_i),
  .rd_o       (rd_o),
  .done_o     (done_o),
  .busy_o     (busy_o),
  .rc_q       (rc_q)
);

// File: tb/test_clmac_unit.sv
module test_clmac_unit;
  localparam int W = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         clr_i = 1'b0;
  logic         rc_we_i = 1'b0;
  logic [W-1:0] rc_i = '0;
  logic         op_valid_i = 1'b0;
  logic         int_mode_i = 1'b0;
  logic [W-1:0] rr_i = '0;
  logic [W-1:0] rd_i = '0;
  logic [W-1:0] rd_o;
  logic         done_o;
  logic         busy_o;

  int           vec_n = 0;
  int           miss_n = 0;
  logic [7:0]   xc_m = '0;
  logic [7:0]   rc_m = '0;

  always #4 clk_i = ~clk_i;

  clmac_unit #(.W(W)) i_clmac_unit (.*);

  function automatic logic [15:0] clmul8(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
    return p;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    vec_n++;
    if (act !== exp) begin
      miss_n++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic load_rc(input logic [7:0] v);
    rc_we_i = 1'b1; rc_i = v;
    @(posedge clk_i); #1;
    rc_we_i = 1'b0;
    rc_m = v;
  endtask

  task automatic clear_xc();
    clr_i = 1'b1;
    @(posedge clk_i); #1;
    clr_i = 1'b0;
    xc_m = '0;
  endtask

  task automatic cl_raw(input logic [7:0] rr, input logic [7:0] rd, output logic [7:0] res);
    op_valid_i = 1'b1; int_mode_i = 1'b0; rr_i = rr; rd_i = rd;
    @(posedge clk_i); #1;
    op_valid_i = 1'b0;
    res = rd_o;
  endtask

  task automatic cl_step(input logic [7:0] rr, input logic [7:0] rd, input string tag);
    logic [15:0] t;
    logic [7:0]  r;
    t = clmul8(rc_m, rr) ^ {8'h00, xc_m} ^ {8'h00, rd};
    cl_raw(rr, rd, r);
    chk(tag, {done_o, r}, {1'b1, t[7:0]});
    xc_m = t[15:8];
  endtask

  task automatic int_step(input logic [7:0] rr, input logic [7:0] rd, input bit poke);
    logic [15:0] t;
    t = 16'(rr) * 16'(rc_m) + 16'(xc_m) + 16'(rd);
    op_valid_i = 1'b1; int_mode_i = 1'b1; rr_i = rr; rd_i = rd;
    @(posedge clk_i); #1;
    chk("R5 busy", busy_o, 1'b1);
    if (poke) begin
      int_mode_i = 1'b0; rr_i = ~rr; rd_i = 8'ha5;  // R6: strobe while busy
    end else begin
      op_valid_i = 1'b0;
    end
    @(posedge clk_i); #1;
    op_valid_i = 1'b0; int_mode_i = 1'b0;
    chk("R5 result", {done_o, busy_o, rd_o}, {1'b1, 1'b0, t[7:0]});
    xc_m = t[15:8];
    if (poke) begin
      @(posedge clk_i); #1;
      chk("R6 ignored", done_o, 1'b0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    miss_n++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
    $finish;
  end

  initial begin
    logic [7:0]   r;
    logic [63:0]  a, b;
    logic [127:0] ref_p, got;
    logic [7:0]   c [16];
    logic [15:0]  t;

    repeat (3) @(posedge clk_i);
    #1;
    chk("R8 in reset", {done_o, busy_o, rd_o}, '0);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R8 after reset", {done_o, busy_o, rd_o}, '0);
    cl_step(8'h5a, 8'h33, "R8 rc zero");
    cl_step(8'h00, 8'h00, "R8 xc zero");

    // R1 R2 R4: carry-less sweep
    for (int ci = 0; ci < 16; ci++) begin
      load_rc(8'(ci * 17));
      for (int rr = 0; rr < 256; rr++) begin
        cl_step(8'(rr), 8'(rr * 7 + ci), "R1 R2 step");
        if (rr % 64 == 63) begin
          cl_step(8'h00, 8'h00, "R4 save");
          cl_step(8'h00, 8'h00, "R4 empty");
        end
      end
    end

    // R3: load and step in the same cycle
    load_rc(8'h3c);
    t = clmul8(8'h3c, 8'h81) ^ {8'h00, xc_m};
    rc_we_i = 1'b1; rc_i = 8'hc5;
    op_valid_i = 1'b1; int_mode_i = 1'b0; rr_i = 8'h81; rd_i = 8'h00;
    @(posedge clk_i); #1;
    rc_we_i = 1'b0; op_valid_i = 1'b0;
    chk("R3 old coef", {done_o, rd_o}, {1'b1, t[7:0]});
    xc_m = t[15:8]; rc_m = 8'hc5;
    cl_step(8'h81, 8'h00, "R3 new coef");
    cl_step(8'h00, 8'h00, "R3 save");

    // R5: integer sweep
    clear_xc();
    for (int ci = 0; ci < 16; ci++) begin
      load_rc(8'(ci * 17));
      for (int rr = 0; rr < 64; rr++) int_step(8'(rr * 4 + ci % 4), 8'(rr * 13 + ci), 1'b0);
      int_step(8'h00, 8'h00, 1'b0);
    end
    load_rc(8'hff);
    xc_m = 8'hff;
    clear_xc();
    int_step(8'hff, 8'hff, 1'b0);
    int_step(8'hff, 8'hff, 1'b0);  // R5 max-term case with nonzero carry

    // R6: strobe during busy leaves carry alone
    int_step(8'h9b, 8'h47, 1'b1);
    cl_step(8'h00, 8'h00, "R6 carry kept");

    // R7: clear with simultaneous strobe
    load_rc(8'hff);
    cl_step(8'hff, 8'h00, "R7 charge");
    clr_i = 1'b1; op_valid_i = 1'b1; int_mode_i = 1'b0; rr_i = 8'h12; rd_i = 8'h34;
    @(posedge clk_i); #1;
    clr_i = 1'b0; op_valid_i = 1'b0;
    xc_m = '0;
    chk("R7 strobe dropped", done_o, 1'b0);
    cl_step(8'h00, 8'h00, "R7 carry zero");

    // R7: clear cancels pending integer step
    cl_step(8'hff, 8'h00, "R7 charge");
    op_valid_i = 1'b1; int_mode_i = 1'b1; rr_i = 8'hee; rd_i = 8'h11;
    @(posedge clk_i); #1;
    op_valid_i = 1'b0; int_mode_i = 1'b0; clr_i = 1'b1;
    @(posedge clk_i); #1;
    clr_i = 1'b0;
    xc_m = '0;
    chk("R7 cancel", {done_o, busy_o}, 2'b00);
    cl_step(8'h00, 8'h00, "R7 carry zero");

    // R9: chained 64x64 carry-less products
    for (int k = 0; k < 16; k++) begin
      a = {$urandom, $urandom};
      b = {$urandom, $urandom};
      if (k == 0) a = '1;
      if (k == 1) b = '1;
      for (int i = 0; i < 16; i++) c[i] = '0;
      clear_xc();
      for (int p = 0; p < 8; p++) begin
        load_rc(a[p*8 +: 8]);
        for (int n = 0; n < 8; n++) begin
          cl_raw(b[n*8 +: 8], c[p+n], r);
          c[p+n] = r;
        end
        cl_raw(8'h00, c[p+8], r);
        c[p+8] = r;
      end
      ref_p = '0;
      for (int i = 0; i < 64; i++)
        for (int j = 0; j < 64; j++)
          if (a[i] && b[j]) ref_p[i+j] = ~ref_p[i+j];
      for (int i = 0; i < 16; i++) got[i*8 +: 8] = c[i];
      chk("R9 chain", got, ref_p);
    end
    xc_m = '0;

    $display("== %0d vectors applied, %0d miscompares ==", vec_n, miss_n);
    $finish;
  end
endmodule